// File: doc/BRIEF.md
# Page-Mapping Address Translator

This block widens a 16-bit processor address into a 24-bit physical address through a small writable map of sixteen page slots. The upper four bits of the logical address choose a slot. The slot holds a 12-bit physical page number, and that number takes the place of those four bits. The lower twelve bits (the offset within a 4 KB page) are carried through untouched. The result is a 16 MB physical space, seen through a 64 KB window.

Software loads slots through a synchronous write port, which takes a slot index, a page number and a strobe. The map is read combinationally, so a translation settles within the cycle in which the address is presented. The map has no defined contents after power-up or reset. Software must fill every slot before it relies on translation.

A bypass input is provided so that boot code can run before the map is filled. When the bypass input is asserted, the logical address goes out zero-extended and the map is not consulted. Decoding of the I/O addresses used to reach the write port belongs to the surrounding logic.

Top module: `mmu_translator`

## Requirements
- R1: The slot consulted for a translation is selected by logical address bits 15:12. Slot k serves logical addresses k*4096 through k*4096+4095.
- R2: With `rom_sel` low, `phys_addr[23:12]` equals the 12-bit page number stored in the selected slot.
- R3: `phys_addr[11:0]` always equals `log_addr[11:0]`, whether or not the bypass is active.
- R4: With `rom_sel` high, `phys_addr` equals `{8'h00, log_addr}`, whatever the map holds.
- R5: A write with `map_we` high stores `map_ppn` into slot `map_idx` at the rising clock edge. Before that edge, translation still shows the old contents. From that edge on, it shows the new value.
- R6: A write to one slot leaves all other slots unchanged.
- R7: The bypass needs no map contents, so it is usable at once after reset. A write made while `rom_sel` is high is still stored.
- R8: While `map_we` is low, changes on `map_idx` and `map_ppn` have no effect on any slot.
- R9: Reset gives the map no defined contents. Correct translation therefore requires software to write each slot first. Bypassed accesses are the only ones that work from reset onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; map writes land on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; it does not clear the map |
| log_addr | input | 16 | Logical address from the processor |
| rom_sel | input | 1 | High: skip translation and zero-extend the address |
| map_we | input | 1 | Map write strobe |
| map_idx | input | 4 | Slot index for a map write |
| map_ppn | input | 12 | Physical page number to store |
| phys_addr | output | 24 | Translated or bypassed physical address |

## Verification
The bound checker compares the ports on every cycle. It confirms that the offset bits always pass through and that a bypassed address is a zero-extended copy. It also confirms that a slot written in one cycle shows its new page number in the next cycle. Finally, it confirms that the output holds steady when neither the address, the bypass nor the map has changed. Only the bench scenarios can show the following, because each needs knowledge of the whole map:
- that every slot maps its own 4 KB range;
- that rewriting one slot disturbs no other;
- that index and data changes without a strobe are ignored;
- that the stored value is invisible until the clock edge.

// File: rtl/mmu_pkg.sv
// Shared sizing for the page-mapping translator.
// Assumes: the physical address is at least as wide as the logical address.
package mmu_pkg;
    localparam int unsigned LOG_W_DEF    = 16;  // processor address width
    localparam int unsigned OFFSET_W_DEF = 12;  // 4 KB pages
    localparam int unsigned PPN_W_DEF    = 12;  // physical page number width
endpackage

// File: rtl/mmu_page_table.sv
// Sixteen-slot (by default) page-number store with one synchronous write port
// and one combinational read port.
// Assumes: contents are undefined until written; reset deliberately does not
// touch the storage, since software owns initialisation.
module mmu_page_table #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned PPN_W = 12
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn
);
    localparam int unsigned SLOTS = 1 << IDX_W;

    logic [PPN_W-1:0] slot_q [SLOTS];

    // One register per slot, each loaded only when its index is written.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Purpose: capture the new page number into this slot on a matching write.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(s))) begin
                slot_q[s] <= wr_ppn;
            end
        end
    end

    // Purpose: combinational lookup of the slot chosen by the read index.
    always_comb begin
        rd_ppn = slot_q[rd_idx];
    end
endmodule

// File: rtl/mmu_addr_compose.sv
// Builds the physical address, either from a page number plus the offset or,
// under bypass, by zero-extending the logical address.
// Assumes: PHYS_W = PPN_W + OFFSET_W and PHYS_W >= LOG_W.
module mmu_addr_compose #(
    parameter int unsigned LOG_W    = 16,
    parameter int unsigned OFFSET_W = 12,
    parameter int unsigned PPN_W    = 12,
    parameter int unsigned PHYS_W   = PPN_W + OFFSET_W
) (
    input  logic [LOG_W-1:0]  log_addr,
    input  logic [PPN_W-1:0]  ppn,
    input  logic              bypass,
    output logic [PHYS_W-1:0] phys_addr
);
    localparam int unsigned EXT_W = PHYS_W - LOG_W;

    // Purpose: choose between the mapped address and the zero-extended one.
    always_comb begin
        if (bypass) begin
            phys_addr = {{EXT_W{1'b0}}, log_addr};
        end else begin
            phys_addr = {ppn, log_addr[OFFSET_W-1:0]};
        end
    end
endmodule

// File: rtl/mmu_translator.sv
// Top of the page-mapping translator. The upper logical bits select a slot,
// the slot's page number replaces them, and the offset passes through.
// Assumes: the surrounding logic decodes the write strobe; rst_n resets no
// state here (the map is software-initialised) and serves the bound checker.
module mmu_translator #(
    parameter int unsigned LOG_W    = mmu_pkg::LOG_W_DEF,
    parameter int unsigned OFFSET_W = mmu_pkg::OFFSET_W_DEF,
    parameter int unsigned PPN_W    = mmu_pkg::PPN_W_DEF,
    parameter int unsigned IDX_W    = LOG_W - OFFSET_W,
    parameter int unsigned PHYS_W   = PPN_W + OFFSET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOG_W-1:0]  log_addr,
    input  logic              rom_sel,
    input  logic              map_we,
    input  logic [IDX_W-1:0]  map_idx,
    input  logic [PPN_W-1:0]  map_ppn,
    output logic [PHYS_W-1:0] phys_addr
);
    logic [IDX_W-1:0] page_sel;
    logic [PPN_W-1:0] page_ppn;

    // Purpose: take the slot index from the top logical bits.
    always_comb begin
        page_sel = log_addr[LOG_W-1:OFFSET_W];
    end

    mmu_page_table #(
        .IDX_W (IDX_W),
        .PPN_W (PPN_W)
    ) u_table (
        .clk    (clk),
        .wr_en  (map_we),
        .wr_idx (map_idx),
        .wr_ppn (map_ppn),
        .rd_idx (page_sel),
        .rd_ppn (page_ppn)
    );

    mmu_addr_compose #(
        .LOG_W    (LOG_W),
        .OFFSET_W (OFFSET_W),
        .PPN_W    (PPN_W),
        .PHYS_W   (PHYS_W)
    ) u_compose (
        .log_addr  (log_addr),
        .ppn       (page_ppn),
        .bypass    (rom_sel),
        .phys_addr (phys_addr)
    );
endmodule

// File: rtl/mmu_translator_chk.sv
// Port-level checker for the translator, attached through bind.
// Assumes: default widths are consistent (PHYS_W = PPN_W + OFFSET_W).
module mmu_translator_chk #(
    parameter int unsigned LOG_W    = 16,
    parameter int unsigned OFFSET_W = 12,
    parameter int unsigned PPN_W    = 12,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned PHYS_W   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LOG_W-1:0]  log_addr,
    input logic              rom_sel,
    input logic              map_we,
    input logic [IDX_W-1:0]  map_idx,
    input logic [PPN_W-1:0]  map_ppn,
    input logic [PHYS_W-1:0] phys_addr
);
    // R3: offset bits always pass through
    a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFFSET_W-1:0] == log_addr[OFFSET_W-1:0]);

    // R4: bypass zero-extends the logical address
    a_r4_bypass_zext: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (phys_addr[PHYS_W-1:LOG_W] == '0 && phys_addr[LOG_W-1:0] == log_addr));

    // R5: a written slot shows its new page number from the next cycle
    a_r5_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> (rom_sel || log_addr[LOG_W-1:OFFSET_W] != $past(map_idx)
                    || phys_addr[PHYS_W-1:OFFSET_W] == $past(map_ppn)));

    // R8: no strobe, same address, no bypass -> output unchanged
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(map_we) && $stable(log_addr) && !rom_sel && !$past(rom_sel))
            |-> $stable(phys_addr));
endmodule

bind mmu_translator mmu_translator_chk #(
    .LOG_W    (LOG_W),
    .OFFSET_W (OFFSET_W),
    .PPN_W    (PPN_W),
    .IDX_W    (IDX_W),
    .PHYS_W   (PHYS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_addr  (log_addr),
    .rom_sel   (rom_sel),
    .map_we    (map_we),
    .map_idx   (map_idx),
    .map_ppn   (map_ppn),
    .phys_addr (phys_addr)
);

// File: tb/sim_mmu_translator.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_mmu_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] log_addr = '0;
    logic        rom_sel = 1'b0;
    logic        map_we = 1'b0;
    logic [3:0]  map_idx = '0;
    logic [11:0] map_ppn = '0;
    logic [23:0] phys_addr;

    int n_run = 0;
    int n_fail = 0;
    logic [11:0] model [16];

    always #2.5 clk = ~clk;  // 200 MHz

    mmu_translator u0 (
        .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .rom_sel(rom_sel),
        .map_we(map_we), .map_idx(map_idx), .map_ppn(map_ppn),
        .phys_addr(phys_addr)
    );

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: phys_addr=%h expected=%h", req, got, exp);
        end
    endtask

    // Inputs change on the falling edge; the write lands on the next rising edge.
    task automatic put_slot(input logic [3:0] idx, input logic [11:0] ppn);
        @(negedge clk);
        map_we = 1'b1; map_idx = idx; map_ppn = ppn;
        @(negedge clk);
        map_we = 1'b0;
        model[idx] = ppn;
    endtask

    function automatic logic [11:0] pat(input int k);
        return 12'((k * 12'h1A3) ^ 12'hC5E);
    endfunction

    task automatic t_reset_bypass;  // R4, R7, R9: bypass usable before any write
        @(negedge clk);
        rom_sel = 1'b1;
        for (int a = 0; a < 65536; a += 4099) begin
            log_addr = 16'(a); #1;
            check("R4/R7", phys_addr, {8'h00, 16'(a)});
        end
        log_addr = 16'hFFFF; #1;
        check("R4", phys_addr, 24'h00FFFF);
        rom_sel = 1'b0;
    endtask

    task automatic t_fill_sweep;  // R1, R2, R3
        for (int k = 0; k < 16; k++) put_slot(4'(k), pat(k));
        for (int k = 0; k < 16; k++) begin
            log_addr = {4'(k), 12'h000}; #1;
            check("R1/R2 low", phys_addr, {pat(k), 12'h000});
            log_addr = {4'(k), 12'hFFF}; #1;
            check("R1/R3 high", phys_addr, {pat(k), 12'hFFF});
            log_addr = {4'(k), 12'h5A3}; #1;
            check("R2/R3 mid", phys_addr, {pat(k), 12'h5A3});
        end
    endtask

    task automatic t_write_timing;  // R5: old value until the edge, new after
        @(negedge clk);
        log_addr = 16'h7123;
        map_we = 1'b1; map_idx = 4'h7; map_ppn = 12'hABC; #1;
        check("R5 before edge", phys_addr, {model[7], 12'h123});
        @(posedge clk); #1;
        check("R5 after edge", phys_addr, {12'hABC, 12'h123});
        @(negedge clk);
        map_we = 1'b0;
        model[7] = 12'hABC;
    endtask

    task automatic t_isolation;  // R6: other slots unchanged
        put_slot(4'h3, 12'h0F0);
        for (int k = 0; k < 16; k++) begin
            log_addr = {4'(k), 12'h010}; #1;
            check("R6", phys_addr, {model[k], 12'h010});
        end
    endtask

    task automatic t_no_strobe;  // R8: index/data without strobe ignored
        @(negedge clk);
        map_we = 1'b0;
        for (int k = 0; k < 16; k++) begin
            map_idx = 4'(k); map_ppn = ~model[k];
            @(negedge clk);
        end
        for (int k = 0; k < 16; k++) begin
            log_addr = {4'(k), 12'h222}; #1;
            check("R8", phys_addr, {model[k], 12'h222});
        end
    endtask

    task automatic t_write_in_bypass;  // R7: write during bypass is stored
        @(negedge clk);
        rom_sel = 1'b1;
        log_addr = 16'hC345;
        map_we = 1'b1; map_idx = 4'hC; map_ppn = 12'h321;
        @(negedge clk);
        map_we = 1'b0; #1;
        check("R7 bypass holds", phys_addr, 24'h00C345);
        model[12] = 12'h321;
        rom_sel = 1'b0; #1;
        check("R7 write kept", phys_addr, {12'h321, 12'h345});
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_bypass();
        t_fill_sweep();
        t_write_timing();
        t_isolation();
        t_no_strobe();
        t_write_in_bypass();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule